// File: doc/BRIEF.md
# DMA transfer mode selector

This block picks the DMA transfer mode to use with an attached storage device. It takes the capability fields reported by the device's identify data, the mode masks the host controller supports, a cable-type input and the mode the software asks for. It returns the fastest mode that both sides support, capped at the requested mode. Three families are considered, fastest first: Ultra DMA, then multiword DMA, then single-word DMA.

A mode code is the family base plus the mode number inside that family. Single-word modes start at 0x10, multiword modes at 0x20 and Ultra modes at 0x40. A code of zero means that no DMA mode is usable. Software pulses `start` with all inputs steady. One cycle later `mode_valid` pulses, `mode_out` holds the chosen code and `bad_identify` reports whether the identify data looked inconsistent. Both outputs keep their values until the next `start`.

Top module: `dma_mode_pick`

## Requirements
- R1: After reset, `mode_out` is 0x00, `mode_valid` is 0 and `bad_identify` is 0.
- R2: `mode_valid` is high exactly in the cycle after a cycle with `start` high. `mode_out` and `bad_identify` change only at that point, whatever happens on the other inputs.
- R3: The Ultra family is used only when `id_ultra_ok` is 1. Its mask is `host_ultra_mask & id_ultra_sup`. The highest set bit n of that mask gives code 0x40+n.
- R4: The multiword family is used only when `id_mw_ok` is 1. Its mask is `host_mw_mask & id_mw_sup`. The highest set bit n gives code 0x20+n.
- R5: When `id_mw_ok` is 1, the single-word mask is `host_sw_mask & id_sw_sup`. The highest set bit n gives code 0x10+n.
- R6: When `id_mw_ok` is 0, the single-word mask comes from `id_sw_legacy`, read as a value m. If m is 1 or 2, the mask is ((2<<m)-1) ANDed with `host_sw_mask`. For any other m the mask is empty.
- R7: Families are tried in the order Ultra, multiword, single-word. The first family with a non-empty mask wins. A family whose base code is greater than `req_mode` is skipped.
- R8: When `req_mode` is greater than 0x42 and `cable80` is 0, Ultra mask bits 3 to 6 are cleared before the Ultra mode is picked.
- R9: The result is the smaller of the picked code and `req_mode`. It is 0x00 when no family yields a mode.
- R10: When `is_disk` is 0 and `no_atapi_dma` is 1, the result is 0x00.
- R11: `bad_identify` is set in either of two cases:
  - `id_ultra_ok` is 1 and both `id_ultra_act` and `id_mw_act` are nonzero.
  - `id_ultra_ok` is 0, `id_mw_ok` is 1, and both `id_mw_act` and `id_sw_act` are nonzero.

  When `bad_identify` is set, the result is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Evaluate the inputs and load the outputs |
| req_mode | input | 8 | Requested mode code (upper limit) |
| id_ultra_ok | input | 1 | Identify Ultra fields are valid |
| id_mw_ok | input | 1 | Identify multiword/single-word fields are valid |
| id_ultra_sup | input | 7 | Device Ultra modes supported |
| id_ultra_act | input | 8 | Device Ultra active-mode byte |
| id_mw_sup | input | 3 | Device multiword modes supported |
| id_mw_act | input | 8 | Device multiword active-mode byte |
| id_sw_sup | input | 3 | Device single-word modes supported |
| id_sw_act | input | 8 | Device single-word active-mode byte |
| id_sw_legacy | input | 8 | Legacy single-word timing mode number |
| host_ultra_mask | input | 7 | Host Ultra modes supported |
| host_mw_mask | input | 3 | Host multiword modes supported |
| host_sw_mask | input | 3 | Host single-word modes supported |
| cable80 | input | 1 | 80-conductor cable detected |
| is_disk | input | 1 | Device is a disk (0 = packet device) |
| no_atapi_dma | input | 1 | Forbid DMA for non-disk devices |
| mode_out | output | 8 | Selected mode code, 0x00 = no DMA |
| mode_valid | output | 1 | One-cycle pulse when a new result is loaded |
| bad_identify | output | 1 | Identify data claims more than one active family |

## Verification
All three results are due in the cycle after `start` has been sampled high. The bench raises `start` on a falling edge, lets one rising edge pass and reads `mode_out`, `bad_identify` and `mode_valid` on the following falling edge. It then drops `start` and reads again one cycle later, with the inputs changed, to confirm that the valid strobe has fallen and that the held outputs did not move.

// File: rtl/dma_mode_pick.sv
module dma_mode_pick #(
  parameter int UW = 7,
  parameter int MW = 3,
  parameter int SW = 3,
  parameter logic [7:0] U_BASE = 8'h40,
  parameter logic [7:0] M_BASE = 8'h20,
  parameter logic [7:0] S_BASE = 8'h10,
  parameter int U_SLOW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    req_mode,
  input  logic          id_ultra_ok,
  input  logic          id_mw_ok,
  input  logic [UW-1:0] id_ultra_sup,
  input  logic [7:0]    id_ultra_act,
  input  logic [MW-1:0] id_mw_sup,
  input  logic [7:0]    id_mw_act,
  input  logic [SW-1:0] id_sw_sup,
  input  logic [7:0]    id_sw_act,
  input  logic [7:0]    id_sw_legacy,
  input  logic [UW-1:0] host_ultra_mask,
  input  logic [MW-1:0] host_mw_mask,
  input  logic [SW-1:0] host_sw_mask,
  input  logic          cable80,
  input  logic          is_disk,
  input  logic          no_atapi_dma,
  output logic [7:0]    mode_out,
  output logic          mode_valid,
  output logic          bad_identify
);
  localparam logic [UW-1:0] U_KEEP = UW'((1 << U_SLOW) - 1);
  localparam logic [7:0] U_CABLE_LIM = U_BASE + 8'(U_SLOW - 1);

  function automatic logic [7:0] hi_idx(input logic [7:0] m);
    hi_idx = 8'd0;
    for (int i = 0; i < 8; i++)
      if (m[i]) hi_idx = 8'(i);
  endfunction

  logic [UW-1:0] u_raw, u_mask;
  logic [MW-1:0] m_mask;
  logic [SW-1:0] s_leg, s_mask;
  logic          bad, block;
  logic [7:0]    pick, res;

  assign u_raw  = host_ultra_mask & id_ultra_sup;
  assign u_mask = (req_mode > U_CABLE_LIM && !cable80) ? (u_raw & U_KEEP) : u_raw;
  assign m_mask = host_mw_mask & id_mw_sup;
  assign s_leg  = (id_sw_legacy != 8'd0 && id_sw_legacy <= 8'd2)
                  ? SW'((8'd2 << id_sw_legacy) - 8'd1) : '0;
  assign s_mask = id_mw_ok ? (host_sw_mask & id_sw_sup) : (host_sw_mask & s_leg);

  assign bad = id_ultra_ok ? (id_ultra_act != 8'd0 && id_mw_act != 8'd0)
             : id_mw_ok    ? (id_mw_act != 8'd0 && id_sw_act != 8'd0)
             : 1'b0;
  assign block = bad || (!is_disk && no_atapi_dma);

  always_comb begin
    pick = 8'd0;
    if (!block) begin
      if (id_ultra_ok && req_mode >= U_BASE && u_mask != '0)
        pick = U_BASE + hi_idx(8'(u_mask));
      else if (id_mw_ok && req_mode >= M_BASE && m_mask != '0)
        pick = M_BASE + hi_idx(8'(m_mask));
      else if (req_mode >= S_BASE && s_mask != '0)
        pick = S_BASE + hi_idx(8'(s_mask));
    end
  end

  assign res = (pick < req_mode) ? pick : req_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_out     <= 8'd0;
      mode_valid   <= 1'b0;
      bad_identify <= 1'b0;
    end else begin
      mode_valid <= start;
      if (start) begin
        mode_out     <= (pick == 8'd0) ? 8'd0 : res;
        bad_identify <= bad;
      end
    end
  end
endmodule

// File: rtl/dma_mode_pick_chk.sv
module dma_mode_pick_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] req_mode,
  input logic       is_disk,
  input logic       no_atapi_dma,
  input logic [7:0] mode_out,
  input logic       mode_valid,
  input logic       bad_identify
);
  // R2
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mode_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!mode_valid && $stable(mode_out) && $stable(bad_identify)));
  // R9
  capped_by_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mode_out <= $past(req_mode)));
  // R10
  atapi_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !is_disk && no_atapi_dma) |=> (mode_out == 8'd0));
  // R11
  bad_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && bad_identify) |-> (mode_out == 8'd0));
  // R3
  family_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && mode_out != 8'd0) |-> $onehot0(mode_out[7:4]));
endmodule

bind dma_mode_pick dma_mode_pick_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_mode(req_mode),
  .is_disk(is_disk), .no_atapi_dma(no_atapi_dma), .mode_out(mode_out),
  .mode_valid(mode_valid), .bad_identify(bad_identify)
);

// File: tb/dma_mode_pick_tb.sv
`timescale 1ns/1ps
module dma_mode_pick_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] req_mode = 8'd0;
  logic id_ultra_ok = 1'b0, id_mw_ok = 1'b0;
  logic [6:0] id_ultra_sup = '0, host_ultra_mask = '0;
  logic [7:0] id_ultra_act = '0, id_mw_act = '0, id_sw_act = '0, id_sw_legacy = '0;
  logic [2:0] id_mw_sup = '0, id_sw_sup = '0, host_mw_mask = '0, host_sw_mask = '0;
  logic cable80 = 1'b0, is_disk = 1'b1, no_atapi_dma = 1'b0;
  logic [7:0] mode_out;
  logic mode_valid, bad_identify;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  dma_mode_pick u_dut (.*);

  function automatic int top_of(input int m);
    int r = -1;
    for (int i = 0; i < 8; i++) if ((m >> i) & 1) r = i;
    return r;
  endfunction

  function automatic logic ref_bad();
    if (id_ultra_ok) return (id_ultra_act != 0) && (id_mw_act != 0);
    if (id_mw_ok) return (id_mw_act != 0) && (id_sw_act != 0);
    return 1'b0;
  endfunction

  function automatic int ref_mode();
    int m, t;
    if (ref_bad()) return 0;
    if (!is_disk && no_atapi_dma) return 0;
    if (id_ultra_ok && req_mode >= 8'h40) begin
      m = int'(host_ultra_mask & id_ultra_sup);
      if (req_mode > 8'h42 && !cable80) m = m & 7;
      t = top_of(m);
      if (t >= 0) return (8'h40 + t < req_mode) ? 8'h40 + t : int'(req_mode);
    end
    if (id_mw_ok && req_mode >= 8'h20) begin
      t = top_of(int'(host_mw_mask & id_mw_sup));
      if (t >= 0) return (8'h20 + t < req_mode) ? 8'h20 + t : int'(req_mode);
    end
    if (req_mode >= 8'h10) begin
      if (id_mw_ok) m = int'(host_sw_mask & id_sw_sup);
      else if (id_sw_legacy == 1) m = int'(host_sw_mask) & 3;
      else if (id_sw_legacy == 2) m = int'(host_sw_mask) & 7;
      else m = 0;
      t = top_of(m);
      if (t >= 0) return (8'h10 + t < req_mode) ? 8'h10 + t : int'(req_mode);
    end
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag);
    int em, eb;
    em = ref_mode();
    eb = int'(ref_bad());
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(tag, int'(mode_out), em);
    check({tag, " bad_identify"}, int'(bad_identify), eb);
    check("R2 valid pulse", int'(mode_valid), 1);
    req_mode = ~req_mode;
    cable80 = ~cable80;
    @(negedge clk);
    check("R2 valid drop", int'(mode_valid), 0);
    check("R2 held mode", int'(mode_out), em);
    req_mode = ~req_mode;
    cable80 = ~cable80;
  endtask

  task automatic base_cfg();
    id_ultra_ok = 1; id_mw_ok = 1; id_ultra_sup = 7'h3f; id_ultra_act = 0;
    id_mw_sup = 3'h7; id_mw_act = 0; id_sw_sup = 3'h7; id_sw_act = 0;
    id_sw_legacy = 0; host_ultra_mask = 7'h7f; host_mw_mask = 3'h7;
    host_sw_mask = 3'h7; cable80 = 1; is_disk = 1; no_atapi_dma = 0;
    req_mode = 8'h46;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset mode", int'(mode_out), 0);
    check("R1 reset valid", int'(mode_valid), 0);
    check("R1 reset bad", int'(bad_identify), 0);
    rst_n = 1'b1;
    @(negedge clk);
    base_cfg(); run("R3 ultra 5");
    base_cfg(); cable80 = 0; run("R8 no cable");
    base_cfg(); cable80 = 0; req_mode = 8'h42; run("R8 low request");
    base_cfg(); req_mode = 8'h44; run("R9 capped");
    base_cfg(); id_ultra_ok = 0; run("R4 multiword");
    base_cfg(); req_mode = 8'h21; run("R7 skip ultra");
    base_cfg(); host_ultra_mask = 0; run("R7 fall to multiword");
    base_cfg(); id_ultra_ok = 0; host_mw_mask = 0; host_sw_mask = 3'h3; run("R5 single");
    base_cfg(); id_ultra_ok = 0; id_mw_ok = 0; id_sw_legacy = 2; run("R6 legacy 2");
    base_cfg(); id_ultra_ok = 0; id_mw_ok = 0; id_sw_legacy = 1; run("R6 legacy 1");
    base_cfg(); id_ultra_ok = 0; id_mw_ok = 0; id_sw_legacy = 3; run("R6 legacy 3");
    base_cfg(); id_ultra_ok = 0; id_mw_ok = 0; id_sw_legacy = 0; run("R6 legacy 0");
    base_cfg(); req_mode = 8'h0f; run("R9 none");
    base_cfg(); id_ultra_act = 8'h20; id_mw_act = 8'h04; run("R11 ultra+mw");
    base_cfg(); id_ultra_ok = 0; id_mw_act = 8'h04; id_sw_act = 8'h01; run("R11 mw+sw");
    base_cfg(); is_disk = 0; no_atapi_dma = 1; run("R10 blocked");
    base_cfg(); is_disk = 0; run("R10 allowed");
    for (int k = 0; k < 400; k++) begin
      id_ultra_ok = 1'($urandom); id_mw_ok = 1'($urandom);
      id_ultra_sup = 7'($urandom); id_mw_sup = 3'($urandom); id_sw_sup = 3'($urandom);
      id_ultra_act = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
      id_mw_act = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
      id_sw_act = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
      id_sw_legacy = 8'($urandom % 5);
      host_ultra_mask = 7'($urandom); host_mw_mask = 3'($urandom);
      host_sw_mask = 3'($urandom); cable80 = 1'($urandom);
      is_disk = ($urandom % 3 != 0); no_atapi_dma = 1'($urandom);
      case ($urandom % 4)
        0: req_mode = 8'h40 + 8'($urandom % 7);
        1: req_mode = 8'h20 + 8'($urandom % 3);
        2: req_mode = 8'h10 + 8'($urandom % 3);
        default: req_mode = 8'($urandom);
      endcase
      run("R7 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule